// File: doc/BRIEF.md
# Control-Flow State Unit with Mode-Banked Flags

This block keeps the control-flow state of a small 8-bit core that has separate program and data memories. It holds a 12-bit program counter, a return stack that lives in its own registers and not in data memory, and the carry and zero flags. The unit keeps one set of these flags for each of the three processor modes: normal, interrupt and non-maskable interrupt (NMI). A mode change selects a different flag set, so no flag needs to be saved to or restored from memory. Neither the program counter nor the flags have a data address.

The instruction decoder drives one-cycle strobes: sequential step, subroutine call, subroutine return, interrupt entry, NMI entry and return-from-interrupt. Call and the two entries take their destination from `target_i`. The ALU side drives a flag-update strobe, an operation kind and the two 8-bit operands. From these the unit computes the new carry and zero for the active mode. A parameter selects whether carry after a subtraction means "no borrow" or "borrow". Every state change is registered and becomes visible on the outputs one clock after the strobe.

Top module: `flowstate_unit`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and the mode to normal (`mode_o` = 0). It clears the carry and zero of all three flag sets, empties the stack and clears both error outputs.
- R2: When step is the only strobe taken, the program counter advances by 1 modulo 4096, so 0xFFF is followed by 0x000.
- R3: A call loads `target_i` into the program counter and pushes the address one past the current one. A return loads the most recent stack entry into the program counter and leaves the mode unchanged.
- R4: The stack holds DEPTH entries (4 or 6). A push into a full stack and a pop from an empty stack each leave the program counter, the mode and the stack unchanged. They set `stk_ovf_o` or `stk_unf_o` respectively, and the flag stays set until reset.
- R5: Interrupt entry is taken only in normal mode. NMI entry is taken in normal or interrupt mode. Either entry pushes the current program counter together with the current mode, loads `target_i`, and sets the mode to 1 (interrupt) or 2 (NMI). An entry that is not allowed in the current mode has no effect.
- R6: Return-from-interrupt pops the most recent entry and restores both its program counter and the mode that was active when the entry was pushed.
- R7: The flags change only in a cycle where `flag_we_i` is high. The update writes the flag set of the mode active in that cycle, even when the same cycle also changes the mode. The other two sets keep their values.
- R8: `flag_op_i` 0 adds: carry is the carry out of the 8-bit sum, and zero is set when the sum is 0x00. Values 2 and 3 pass `opa_i` through: zero is set when `opa_i` is 0x00 and carry is held.
- R9: `flag_op_i` 1 subtracts `opb_i` from `opa_i`, and zero is set when the difference is 0x00. With SUB_BORROW = 1, carry is 1 exactly when `opa_i` < `opb_i`. With SUB_BORROW = 0, carry is 1 exactly when `opa_i` >= `opb_i`.
- R10: When several strobes are high in one cycle, only one takes effect, in this priority order: NMI entry, interrupt entry, return-from-interrupt, return, call, step. An entry that is not allowed in the current mode is skipped and the next strobe in the order is considered.
- R11: `carry_o` and `zero_o` always show the flag set of the mode reported on `mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | Advance program counter by one |
| call_i | input | 1 | Subroutine call to `target_i` |
| ret_i | input | 1 | Subroutine return |
| irq_i | input | 1 | Interrupt entry to `target_i` |
| nmi_i | input | 1 | NMI entry to `target_i` |
| reti_i | input | 1 | Return from interrupt |
| target_i | input | PC_W | Destination for call and entries |
| flag_we_i | input | 1 | Flag update strobe |
| flag_op_i | input | 2 | 0 add, 1 subtract, 2/3 pass |
| opa_i | input | 8 | First ALU operand |
| opb_i | input | 8 | Second ALU operand |
| pc_o | output | PC_W | Program counter |
| mode_o | output | 2 | 0 normal, 1 interrupt, 2 NMI |
| carry_o | output | 1 | Carry of the active flag set |
| zero_o | output | 1 | Zero of the active flag set |
| stk_ovf_o | output | 1 | Sticky push-into-full error |
| stk_unf_o | output | 1 | Sticky pop-from-empty error |

## Verification
The assertions check several properties on every cycle. The stack fill never goes beyond DEPTH. The error flags rise after a bad push or pop and then stay set. A blocked operation leaves the program counter and the mode frozen. The mode never takes the unused code 3. A lone step advances the counter. A flag set whose mode is inactive never changes. Other behaviours depend on a chain of operations and only the bench scenarios can show them: the exact return address after nested calls and interrupts, which mode a return-from-interrupt restores, the sum and difference carry values under both carry conventions, and which strobe wins when several are high at once.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    localparam int DATA_W    = 8;
    localparam int NUM_MODES = 3;
    localparam int MODE_W    = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_NORM = 2'd0,
        MODE_IRQ  = 2'd1,
        MODE_NMI  = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        FOP_ADD   = 2'd0,
        FOP_SUB   = 2'd1,
        FOP_PASS  = 2'd2,
        FOP_PASS2 = 2'd3
    } fop_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_STEP,
        CMD_CALL,
        CMD_RET,
        CMD_RETI,
        CMD_IRQ,
        CMD_NMI
    } cmd_e;

    typedef struct packed {
        logic carry;
        logic zero;
    } flags_t;

    typedef struct packed {
        logic nmi;
        logic irq;
        logic reti;
        logic ret;
        logic call;
        logic step;
    } req_t;

    // Pick the single command that wins this cycle; entries illegal in the
    // current mode are skipped so a lower-priority strobe can still win.
    function automatic cmd_e pick_cmd(mode_e m, req_t r);
        cmd_e c;
        c = CMD_NONE;
        if (r.nmi && (m != MODE_NMI))        c = CMD_NMI;
        else if (r.irq && (m == MODE_NORM))  c = CMD_IRQ;
        else if (r.reti)                     c = CMD_RETI;
        else if (r.ret)                      c = CMD_RET;
        else if (r.call)                     c = CMD_CALL;
        else if (r.step)                     c = CMD_STEP;
        return c;
    endfunction

    function automatic logic is_push(cmd_e c);
        return (c == CMD_CALL) || (c == CMD_IRQ) || (c == CMD_NMI);
    endfunction

    function automatic logic is_pop(cmd_e c);
        return (c == CMD_RET) || (c == CMD_RETI);
    endfunction

    // New flag pair from an ALU operation; borrow_conv selects the
    // meaning of carry after subtraction.
    function automatic flags_t eval_flags(flags_t cur, fop_e op,
                                          logic [DATA_W-1:0] a,
                                          logic [DATA_W-1:0] b,
                                          logic borrow_conv);
        flags_t          f;
        logic [DATA_W:0] wide;
        f    = cur;
        wide = '0;
        case (op)
            FOP_ADD: begin
                wide    = {1'b0, a} + {1'b0, b};
                f.carry = wide[DATA_W];
                f.zero  = (wide[DATA_W-1:0] == '0);
            end
            FOP_SUB: begin
                wide    = {1'b0, a} - {1'b0, b};
                f.carry = borrow_conv ? wide[DATA_W] : ~wide[DATA_W];
                f.zero  = (wide[DATA_W-1:0] == '0);
            end
            default: begin
                f.zero  = (a == '0);
            end
        endcase
        return f;
    endfunction

endpackage

// File: rtl/cfs_ret_stack.sv
module cfs_ret_stack #(
    parameter int DEPTH = 6,
    parameter int W     = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty,
    output logic         ovf,
    output logic         unf
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] top_slot;

    assign full     = (cnt == CNT_W'(DEPTH));
    assign empty    = (cnt == '0);
    assign top_slot = cnt - 1'b1;
    assign dout     = empty ? '0 : mem[top_slot[IDX_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
            unf <= 1'b0;
        end else if (push) begin
            if (full) ovf <= 1'b1;
            else      cnt <= cnt + 1'b1;
        end else if (pop) begin
            if (empty) unf <= 1'b1;
            else       cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && push && !full) mem[cnt[IDX_W-1:0]] <= din;
    end

    // R4
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH));
    // R4
    ovf_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> ovf);
    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
    // R4
    unf_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && empty) |=> unf);
    // R4
    unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        unf |=> unf);
    // R10
    one_op_chk: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));

endmodule

// File: rtl/cfs_flag_bank.sv
module cfs_flag_bank
    import cfs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  mode_e  mode,
    input  logic   we,
    input  flags_t nxt,
    output flags_t cur
);
    flags_t bank [NUM_MODES];

    for (genvar i = 0; i < NUM_MODES; i++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst)
                bank[i] <= '0;
            else if (we && (mode == mode_e'(i)))
                bank[i] <= nxt;
        end

        // R7
        idle_set_chk: assert property (@(posedge clk) disable iff (rst)
            (mode != mode_e'(i)) |=> $stable(bank[i]));
        // R7
        no_we_chk: assert property (@(posedge clk) disable iff (rst)
            !we |=> $stable(bank[i]));
    end

    always_comb begin
        cur = bank[0];
        for (int k = 0; k < NUM_MODES; k++)
            if (mode == mode_e'(k)) cur = bank[k];
    end

endmodule

// File: rtl/cfs_ctl.sv
module cfs_ctl
    import cfs_pkg::*;
#(
    parameter int PC_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  req_t            req,
    input  logic [PC_W-1:0] target,
    input  logic            stk_full,
    input  logic            stk_empty,
    input  logic [PC_W-1:0] top_pc,
    input  mode_e           top_mode,
    output logic [PC_W-1:0] pc,
    output mode_e           mode,
    output logic            push,
    output logic            pop,
    output logic [PC_W-1:0] push_pc,
    output mode_e           push_mode
);
    cmd_e cmd;
    logic blocked;

    assign cmd       = pick_cmd(mode, req);
    assign push      = is_push(cmd);
    assign pop       = is_pop(cmd);
    assign blocked   = (push && stk_full) || (pop && stk_empty);
    assign push_pc   = (cmd == CMD_CALL) ? pc + 1'b1 : pc;
    assign push_mode = mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc   <= '0;
            mode <= MODE_NORM;
        end else if (!blocked) begin
            case (cmd)
                CMD_STEP: pc <= pc + 1'b1;
                CMD_CALL: pc <= target;
                CMD_IRQ: begin
                    pc   <= target;
                    mode <= MODE_IRQ;
                end
                CMD_NMI: begin
                    pc   <= target;
                    mode <= MODE_NMI;
                end
                CMD_RET:  pc <= top_pc;
                CMD_RETI: begin
                    pc   <= top_pc;
                    mode <= top_mode;
                end
                default: ;
            endcase
        end
    end

    // R2
    step_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_STEP) |=> (pc == PC_W'($past(pc) + 1'b1)));
    // R4
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        blocked |=> ($stable(pc) && $stable(mode)));
    // R5
    irq_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_IRQ && !stk_full) |=> (mode == MODE_IRQ));
    // R5
    legal_mode_chk: assert property (@(posedge clk) disable iff (rst)
        mode != mode_e'(2'd3));

endmodule

// File: rtl/flowstate_unit.sv
module flowstate_unit
    import cfs_pkg::*;
#(
    parameter int PC_W       = 12,
    parameter int DEPTH      = 6,
    parameter bit SUB_BORROW = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic              irq_i,
    input  logic              nmi_i,
    input  logic              reti_i,
    input  logic [PC_W-1:0]   target_i,
    input  logic              flag_we_i,
    input  logic [1:0]        flag_op_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [1:0]        mode_o,
    output logic              carry_o,
    output logic              zero_o,
    output logic              stk_ovf_o,
    output logic              stk_unf_o
);
    localparam int ENT_W = PC_W + MODE_W;

    req_t             req;
    mode_e            mode;
    logic             push, pop, full, empty;
    logic [PC_W-1:0]  push_pc;
    mode_e            push_mode;
    logic [ENT_W-1:0] ent_in, ent_out;
    flags_t           flg_cur, flg_nxt;

    assign req = '{nmi: nmi_i, irq: irq_i, reti: reti_i,
                   ret: ret_i, call: call_i, step: step_i};

    cfs_ctl #(.PC_W(PC_W)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .target    (target_i),
        .stk_full  (full),
        .stk_empty (empty),
        .top_pc    (ent_out[PC_W-1:0]),
        .top_mode  (mode_e'(ent_out[ENT_W-1:PC_W])),
        .pc        (pc_o),
        .mode      (mode),
        .push      (push),
        .pop       (pop),
        .push_pc   (push_pc),
        .push_mode (push_mode)
    );

    assign ent_in = {push_mode, push_pc};

    cfs_ret_stack #(.DEPTH(DEPTH), .W(ENT_W)) u_stk (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .din   (ent_in),
        .dout  (ent_out),
        .full  (full),
        .empty (empty),
        .ovf   (stk_ovf_o),
        .unf   (stk_unf_o)
    );

    assign flg_nxt = eval_flags(flg_cur, fop_e'(flag_op_i), opa_i, opb_i,
                                SUB_BORROW);

    cfs_flag_bank u_flg (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .we   (flag_we_i),
        .nxt  (flg_nxt),
        .cur  (flg_cur)
    );

    assign mode_o  = mode;
    assign carry_o = flg_cur.carry;
    assign zero_o  = flg_cur.zero;

endmodule

// File: tb/flowstate_unit_tb.sv
module flowstate_unit_tb;
    localparam int PC_W  = 12;
    localparam int DEPTH = 6;
    localparam int PMASK = (1 << PC_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step_i = 0, call_i = 0, ret_i = 0, irq_i = 0, nmi_i = 0, reti_i = 0;
    logic [PC_W-1:0] target_i = '0;
    logic flag_we_i = 0;
    logic [1:0] flag_op_i = '0;
    logic [7:0] opa_i = '0, opb_i = '0;
    logic [PC_W-1:0] pc_o, a_pc;
    logic [1:0] mode_o, a_mode;
    logic carry_o, zero_o, stk_ovf_o, stk_unf_o;
    logic a_c, a_z, a_ovf, a_unf;

    int n_chk = 0, n_fail = 0;
    string phase = "R1";
    bit finished = 0;

    always #10 clk = ~clk;

    flowstate_unit #(.PC_W(PC_W), .DEPTH(DEPTH), .SUB_BORROW(1'b1)) u_dut (
        .clk(clk), .rst(rst), .step_i(step_i), .call_i(call_i), .ret_i(ret_i),
        .irq_i(irq_i), .nmi_i(nmi_i), .reti_i(reti_i), .target_i(target_i),
        .flag_we_i(flag_we_i), .flag_op_i(flag_op_i), .opa_i(opa_i),
        .opb_i(opb_i), .pc_o(pc_o), .mode_o(mode_o), .carry_o(carry_o),
        .zero_o(zero_o), .stk_ovf_o(stk_ovf_o), .stk_unf_o(stk_unf_o));

    // second instance: four-entry stack, carry convention "no borrow"
    flowstate_unit #(.PC_W(PC_W), .DEPTH(4), .SUB_BORROW(1'b0)) u_alt (
        .clk(clk), .rst(rst), .step_i(step_i), .call_i(call_i), .ret_i(ret_i),
        .irq_i(irq_i), .nmi_i(nmi_i), .reti_i(reti_i), .target_i(target_i),
        .flag_we_i(flag_we_i), .flag_op_i(flag_op_i), .opa_i(opa_i),
        .opb_i(opb_i), .pc_o(a_pc), .mode_o(a_mode), .carry_o(a_c),
        .zero_o(a_z), .stk_ovf_o(a_ovf), .stk_unf_o(a_unf));

    // ---------------- behavioural reference model ----------------
    int m_pc, m_mode, m_ovf, m_unf;
    int m_c[3], m_z[3];
    int q_pc[$], q_md[$];

    always @(posedge clk) begin
        int s, w;
        if (rst) begin
            m_pc = 0; m_mode = 0; m_ovf = 0; m_unf = 0;
            for (int k = 0; k < 3; k++) begin m_c[k] = 0; m_z[k] = 0; end
            q_pc.delete(); q_md.delete();
        end else begin
            if (flag_we_i) begin
                if (flag_op_i == 2'd0) begin
                    s = int'(opa_i) + int'(opb_i);
                    m_c[m_mode] = (s > 255) ? 1 : 0;
                    m_z[m_mode] = ((s % 256) == 0) ? 1 : 0;
                end else if (flag_op_i == 2'd1) begin
                    m_c[m_mode] = (opa_i < opb_i) ? 1 : 0;
                    m_z[m_mode] = (opa_i == opb_i) ? 1 : 0;
                end else begin
                    m_z[m_mode] = (opa_i == 8'h00) ? 1 : 0;
                end
            end
            w = 0;
            if (nmi_i && m_mode != 2)      w = 6;
            else if (irq_i && m_mode == 0) w = 5;
            else if (reti_i)               w = 4;
            else if (ret_i)                w = 3;
            else if (call_i)               w = 2;
            else if (step_i)               w = 1;
            if (w == 1) m_pc = (m_pc + 1) & PMASK;
            else if (w == 2 || w == 5 || w == 6) begin
                if (q_pc.size() == DEPTH) m_ovf = 1;
                else begin
                    q_pc.push_back(w == 2 ? ((m_pc + 1) & PMASK) : m_pc);
                    q_md.push_back(m_mode);
                    m_pc = int'(target_i);
                    if (w == 5) m_mode = 1;
                    if (w == 6) m_mode = 2;
                end
            end else if (w == 3 || w == 4) begin
                if (q_pc.size() == 0) m_unf = 1;
                else begin
                    m_pc = q_pc.pop_back();
                    s = q_md.pop_back();
                    if (w == 4) m_mode = s;
                end
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cmp_model();
        n_chk++;
        if (int'(pc_o) != m_pc || int'(mode_o) != m_mode ||
            int'(carry_o) != m_c[m_mode] || int'(zero_o) != m_z[m_mode] ||
            int'(stk_ovf_o) != m_ovf || int'(stk_unf_o) != m_unf) begin
            n_fail++;
            $display("FAIL %s (R11 model): actual pc=%0h md=%0d c=%0d z=%0d o=%0d u=%0d expected pc=%0h md=%0d c=%0d z=%0d o=%0d u=%0d",
                     phase, pc_o, mode_o, carry_o, zero_o, stk_ovf_o, stk_unf_o,
                     m_pc, m_mode, m_c[m_mode], m_z[m_mode], m_ovf, m_unf);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cmp_model();
        {step_i, call_i, ret_i, irq_i, nmi_i, reti_i, flag_we_i} = '0;
    endtask

    task automatic flag_op(int op, int a, int b);
        flag_we_i = 1; flag_op_i = 2'(op); opa_i = 8'(a); opb_i = 8'(b);
        tick();
    endtask

    task automatic do_call(int t);
        call_i = 1; target_i = PC_W'(t); tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        cmp_model();
        chk("R1 pc", int'(pc_o), 0);
        chk("R1 mode", int'(mode_o), 0);
        chk("R1 flags", int'({carry_o, zero_o}), 0);
        chk("R1 errors", int'({stk_ovf_o, stk_unf_o}), 0);

        phase = "R2";
        repeat (3) begin step_i = 1; tick(); end
        chk("R2 step", int'(pc_o), 3);
        phase = "R3";
        do_call(12'hFFF);
        chk("R3 call", int'(pc_o), 12'hFFF);
        phase = "R2";
        step_i = 1; tick();
        chk("R2 wrap", int'(pc_o), 0);
        phase = "R3";
        ret_i = 1; tick();
        chk("R3 ret", int'(pc_o), 4);

        phase = "R8";
        flag_op(0, 8'h80, 8'h80);
        chk("R8 add carry/zero", int'({carry_o, zero_o}), 2'b11);
        flag_op(0, 1, 2);
        chk("R8 add plain", int'({carry_o, zero_o}), 2'b00);
        phase = "R9";
        flag_op(1, 3, 5);
        chk("R9 sub underflow borrow", int'({carry_o, zero_o}), 2'b10);
        chk("R9 sub underflow carry-conv", int'(a_c), 0);
        flag_op(1, 5, 5);
        chk("R9 sub equal borrow", int'({carry_o, zero_o}), 2'b01);
        chk("R9 sub equal carry-conv", int'(a_c), 1);
        phase = "R8";
        flag_op(2, 0, 8'hFF);
        chk("R8 pass holds carry", int'({carry_o, zero_o}), 2'b01);
        flag_op(1, 3, 5);
        phase = "R7";
        flag_we_i = 0; flag_op_i = 2'd1; opa_i = 0; opb_i = 0; tick();
        chk("R7 no strobe no change", int'({carry_o, zero_o}), 2'b10);

        phase = "R5";
        irq_i = 1; target_i = 12'h100; tick();
        chk("R5 irq pc", int'(pc_o), 12'h100);
        chk("R5 irq mode", int'(mode_o), 1);
        chk("R11 irq set fresh", int'({carry_o, zero_o}), 2'b00);
        flag_op(0, 8'hFF, 8'h01);
        irq_i = 1; target_i = 12'h200; tick();
        chk("R5 irq in irq ignored", int'(pc_o), 12'h100);
        nmi_i = 1; target_i = 12'h300; tick();
        chk("R5 nmi mode", int'(mode_o), 2);
        chk("R11 nmi set fresh", int'({carry_o, zero_o}), 2'b00);
        nmi_i = 1; irq_i = 1; target_i = 12'h444; tick();
        chk("R5 entries in nmi ignored", int'(pc_o), 12'h300);
        phase = "R6";
        reti_i = 1; tick();
        chk("R6 reti pc", int'(pc_o), 12'h100);
        chk("R6 reti to irq flags", int'({mode_o, carry_o, zero_o}), 4'b0111);
        reti_i = 1; tick();
        chk("R6 reti pc normal", int'(pc_o), 4);
        chk("R6 reti to normal flags", int'({mode_o, carry_o, zero_o}), 4'b0010);

        phase = "R10";
        call_i = 1; step_i = 1; target_i = 12'h050; tick();
        chk("R10 call beats step", int'(pc_o), 12'h050);
        ret_i = 1; call_i = 1; target_i = 12'h777; tick();
        chk("R10 ret beats call", int'(pc_o), 5);
        nmi_i = 1; irq_i = 1; target_i = 12'h300; tick();
        chk("R10 nmi beats irq", int'(mode_o), 2);
        reti_i = 1; tick();
        phase = "R7";
        flag_we_i = 1; flag_op_i = 2'd0; opa_i = 0; opb_i = 0;
        irq_i = 1; target_i = 12'h100; tick();
        chk("R7 irq set untouched", int'({carry_o, zero_o}), 2'b11);
        reti_i = 1; tick();
        chk("R7 old mode set written", int'({mode_o, carry_o, zero_o}), 4'b0001);

        phase = "R4";
        for (int k = 0; k < DEPTH; k++) do_call(12'h010 + k);
        chk("R4 full no error", int'(stk_ovf_o), 0);
        do_call(12'h099);
        chk("R4 overflow pc frozen", int'(pc_o), 12'h015);
        chk("R4 overflow flag", int'(stk_ovf_o), 1);
        chk("R4 depth-4 overflow", int'(a_ovf), 1);
        for (int k = 0; k < DEPTH; k++) begin ret_i = 1; tick(); end
        chk("R4 unwind pc", int'(pc_o), 6);
        ret_i = 1; tick();
        chk("R4 underflow flag", int'(stk_unf_o), 1);
        chk("R4 underflow pc frozen", int'(pc_o), 6);
        chk("R4 overflow sticky", int'(stk_ovf_o), 1);

        phase = "R1";
        rst = 1; tick(); rst = 0; tick();
        chk("R1 reset again", int'({pc_o, mode_o, stk_ovf_o, stk_unf_o}), 0);

        phase = "R10";
        for (int k = 0; k < 4000; k++) begin
            step_i = ($urandom % 2) == 0;
            call_i = ($urandom % 5) == 0;
            ret_i  = ($urandom % 5) == 0;
            irq_i  = ($urandom % 7) == 0;
            nmi_i  = ($urandom % 11) == 0;
            reti_i = ($urandom % 6) == 0;
            target_i  = PC_W'($urandom);
            flag_we_i = ($urandom % 2) == 0;
            flag_op_i = 2'($urandom);
            opa_i = (($urandom % 4) == 0) ? 8'h00 : 8'($urandom);
            opb_i = 8'($urandom);
            if (k % 1000 == 999) rst = 1;
            tick();
            rst = 0;
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule